// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block merges a wide bank of peripheral interrupt lines and a small set of trap lines into one request toward the CPU. It also presents the number of the winning vector and the program address of that vector's table entry. Traps cannot be masked and always beat peripheral sources. Each peripheral source carries an enable bit and a 3-bit priority level that are written through a simple configuration port. A peripheral request reaches the CPU only when its level is strictly above the CPU's current running priority.

Arbitration has two stages. Among peripheral sources, the programmed level decides first, and the fixed position in the vector table breaks ties. A single table-select input moves every lookup to an alternate table. That table lies directly after the primary table and uses the same layout.

Requests are captured into sticky pending flags. The CPU clears a flag by acknowledging its vector number. The winner, its entry address and the request line are all registered, so the arbitration latency is fixed.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0, `irq_vec` is 0 and `irq_addr` is 0. Every pending flag is cleared. Every source's priority is 0 and its enable is 0.
- R2: A pending trap is forwarded regardless of `cpu_prio`, enables and priorities, and it beats every peripheral source. Trap i uses vector i. Among traps the lowest index wins.
- R3: Peripheral source j uses vector `N_TRAP + j`, which is 8 + j with the default parameters.
- R4: A pending peripheral source is forwarded only when its enable is 1, its priority is nonzero and its priority is strictly greater than `cpu_prio`. A change of `cpu_prio` takes effect at the next output update.
- R5: Among forwardable peripheral sources, the highest priority level wins. A tie goes to the lower vector number.
- R6: With `alt_tbl`=0 the entry address is 0x000004 + 2·vector. With `alt_tbl`=1 it is 0x000004 + 2·126 + 2·vector, which is 0x000100 + 2·vector.
- R7: A request sampled at rising edge k sets its pending flag there. The registered outputs reflect it at edge k+1.
- R8: Pending flags are sticky, so a one-cycle request pulse stays pending. An acknowledge (`ack`=1 with `ack_vec`=v) clears only vector v's flag. If the request is still high at that same edge, the clear wins.
- R9: A request from a disabled source is still captured as pending. It is forwarded once the source is enabled.
- R10: A configuration write (`cfg_we`=1) sets the enable and priority of source `cfg_sel` at that edge.
- R11: While nothing is forwarded, `irq` is 0 and `irq_vec` and `irq_addr` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | N_TRAP | Trap request lines |
| usr_req | input | N_USER | Peripheral request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | USR_W | Peripheral source index to configure |
| cfg_en | input | 1 | Enable value to write |
| cfg_prio | input | 3 | Priority level to write (0 = off) |
| alt_tbl | input | 1 | Selects the alternate vector table |
| cpu_prio | input | 3 | CPU's current running priority |
| ack | input | 1 | CPU acknowledge strobe |
| ack_vec | input | VEC_W | Vector number being acknowledged |
| irq | output | 1 | Single interrupt request to the CPU |
| irq_vec | output | VEC_W | Winning vector number |
| irq_addr | output | ADDR_W | Program address of the winning table entry |

## Verification
The bench builds the block with its defaults: 8 traps and 118 peripheral sources, giving the full 126-vector map. With these values, both ends of the map can be driven: trap vector 0, and peripheral vector 125 whose entry address is 0x0000FE. Both table bases, 0x000004 and 0x000100, can also be reached. Priority levels 1 through 7 against running priorities 0, 2, 3, 4, 6 and 7 cover the strict-greater masking edge and the fully masked case.

// File: rtl/irqc_pkg.sv
// Shared definitions for the interrupt controller.
// Assumes: priority levels fit in 3 bits, with level 0 meaning "off".
package irqc_pkg;
    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;

    // Index width for n items, never below 1.
    function automatic int idx_w(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
// Per-source enable and priority storage for peripheral sources.
// Assumes: one write per cycle; an index at or beyond N_USER is dropped.
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int N_USER = 118,
    localparam int USR_W = idx_w(N_USER)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [USR_W-1:0] cfg_sel,
    input  logic             cfg_en,
    input  prio_t            cfg_prio,
    output logic [N_USER-1:0] en_q,
    output prio_t            prio_q [N_USER]
);
    for (genvar j = 0; j < N_USER; j++) begin : g_src
        localparam logic [USR_W-1:0] MY_IDX = USR_W'(j);
        // Update one source's settings when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[j]   <= 1'b0;
                prio_q[j] <= '0;
            end else if (cfg_we && cfg_sel == MY_IDX) begin
                en_q[j]   <= cfg_en;
                prio_q[j] <= cfg_prio;
            end
        end
    end
endmodule

// File: rtl/irqc_pending.sv
// Sticky pending flags: a request sets a flag and a clear strobe resets it.
// Assumes: clear takes precedence over a request at the same edge.
module irqc_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    // Capture requests; acknowledged flags drop even if still requested.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend | req) & ~clr;
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Combinational two-stage selection: lowest pending trap, else the
// peripheral source with the highest level above the CPU level, with
// ties going to the lowest index.
// Assumes: eligible peripheral levels are at least 1.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N_TRAP = 8,
    parameter int N_USER = 118,
    localparam int TRAP_W = idx_w(N_TRAP),
    localparam int USR_W  = idx_w(N_USER)
) (
    input  logic [N_TRAP-1:0] trap_pend,
    input  logic [N_USER-1:0] usr_pend,
    input  logic [N_USER-1:0] en_q,
    input  prio_t             prio_q [N_USER],
    input  prio_t             cpu_prio,
    output logic              trap_hit,
    output logic [TRAP_W-1:0] trap_idx,
    output logic              usr_hit,
    output logic [USR_W-1:0]  usr_idx
);
    // Trap stage: fixed order, lowest index wins.
    always_comb begin
        trap_hit = 1'b0;
        trap_idx = '0;
        for (int i = N_TRAP - 1; i >= 0; i--) begin
            if (trap_pend[i]) begin
                trap_hit = 1'b1;
                trap_idx = TRAP_W'(i);
            end
        end
    end

    // Peripheral stage: level first, then position; descending scan with >=.
    always_comb begin
        prio_t best;
        best    = '0;
        usr_hit = 1'b0;
        usr_idx = '0;
        for (int i = N_USER - 1; i >= 0; i--) begin
            if (usr_pend[i] && en_q[i] && (prio_q[i] > cpu_prio)
                && (prio_q[i] >= best)) begin
                best    = prio_q[i];
                usr_hit = 1'b1;
                usr_idx = USR_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_vecaddr.sv
// Maps a vector number to its table entry address in program memory.
// Assumes: entries are two address units apart and the alternate table
// follows the primary one immediately with the same layout.
module irqc_vecaddr #(
    parameter int N_VEC  = 126,
    parameter int ADDR_W = 24,
    parameter int BASE   = 4,
    parameter int VEC_W  = 7
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic              alt,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] PRI_BASE = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] ALT_BASE = ADDR_W'(BASE + 2 * N_VEC);

    // Pick the table base and add the scaled vector offset.
    always_comb begin
        addr = (alt ? ALT_BASE : PRI_BASE) + ADDR_W'({vec, 1'b0});
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the vectored priority interrupt controller. Captures trap and
// peripheral requests, arbitrates them, and registers the request, the
// winning vector and its entry address (a fixed one-cycle arbitration stage).
// Assumes: the CPU acknowledges by vector number, and reset is synchronous.
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_TRAP = 8,
    parameter int N_USER = 118,
    parameter int ADDR_W = 24,
    parameter int BASE   = 4,
    localparam int N_VEC  = N_TRAP + N_USER,
    localparam int VEC_W  = idx_w(N_VEC),
    localparam int TRAP_W = idx_w(N_TRAP),
    localparam int USR_W  = idx_w(N_USER)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRAP-1:0] trap_req,
    input  logic [N_USER-1:0] usr_req,
    input  logic              cfg_we,
    input  logic [USR_W-1:0]  cfg_sel,
    input  logic              cfg_en,
    input  logic [2:0]        cfg_prio,
    input  logic              alt_tbl,
    input  logic [2:0]        cpu_prio,
    input  logic              ack,
    input  logic [VEC_W-1:0]  ack_vec,
    output logic              irq,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [ADDR_W-1:0] irq_addr
);
    logic [N_TRAP-1:0] trap_clr, trap_pend;
    logic [N_USER-1:0] usr_clr, usr_pend, en_q;
    prio_t             prio_q [N_USER];
    logic              trap_hit, usr_hit;
    logic [TRAP_W-1:0] trap_idx;
    logic [USR_W-1:0]  usr_idx;
    logic [VEC_W-1:0]  nxt_vec;
    logic [ADDR_W-1:0] nxt_addr;

    // Decode the acknowledge into per-flag clear strobes.
    for (genvar i = 0; i < N_TRAP; i++) begin : g_tclr
        localparam logic [VEC_W-1:0] V = VEC_W'(i);
        assign trap_clr[i] = ack && (ack_vec == V);
    end
    for (genvar j = 0; j < N_USER; j++) begin : g_uclr
        localparam logic [VEC_W-1:0] V = VEC_W'(N_TRAP + j);
        assign usr_clr[j] = ack && (ack_vec == V);
    end

    irqc_cfg_regs #(.N_USER(N_USER)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_en(cfg_en), .cfg_prio(cfg_prio), .en_q(en_q), .prio_q(prio_q)
    );

    irqc_pending #(.N(N_TRAP)) i_tpend (
        .clk(clk), .rst_n(rst_n), .req(trap_req), .clr(trap_clr), .pend(trap_pend)
    );

    irqc_pending #(.N(N_USER)) i_upend (
        .clk(clk), .rst_n(rst_n), .req(usr_req), .clr(usr_clr), .pend(usr_pend)
    );

    irqc_arbiter #(.N_TRAP(N_TRAP), .N_USER(N_USER)) i_arb (
        .trap_pend(trap_pend), .usr_pend(usr_pend), .en_q(en_q), .prio_q(prio_q),
        .cpu_prio(cpu_prio), .trap_hit(trap_hit), .trap_idx(trap_idx),
        .usr_hit(usr_hit), .usr_idx(usr_idx)
    );

    // Merge the two stages into one vector number; traps take precedence.
    always_comb begin
        if (trap_hit) nxt_vec = VEC_W'(trap_idx);
        else          nxt_vec = VEC_W'(N_TRAP) + VEC_W'(usr_idx);
    end

    irqc_vecaddr #(.N_VEC(N_VEC), .ADDR_W(ADDR_W), .BASE(BASE), .VEC_W(VEC_W)) i_va (
        .vec(nxt_vec), .alt(alt_tbl), .addr(nxt_addr)
    );

    // Register the outcome; an idle result reads as all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            irq_vec  <= '0;
            irq_addr <= '0;
        end else if (trap_hit || usr_hit) begin
            irq      <= 1'b1;
            irq_vec  <= nxt_vec;
            irq_addr <= nxt_addr;
        end else begin
            irq      <= 1'b0;
            irq_vec  <= '0;
            irq_addr <= '0;
        end
    end
endmodule

// File: rtl/irqc_checker.sv
// Temporal checks on the interrupt controller, attached by bind.
// Assumes: the same parameter values as the bound instance.
module irqc_checker #(
    parameter int N_TRAP = 8,
    parameter int N_USER = 118,
    parameter int ADDR_W = 24,
    parameter int BASE   = 4,
    parameter int VEC_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [ADDR_W-1:0] irq_addr,
    input logic [N_TRAP-1:0] trap_pend,
    input logic [N_USER-1:0] usr_pend
);
    localparam int N_VEC = N_TRAP + N_USER;
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + 4 * N_VEC);
    localparam logic [VEC_W-1:0]  NT = VEC_W'(N_TRAP);
    localparam logic [VEC_W-1:0]  NV = VEC_W'(N_VEC);

    // R1: the cycle after reset is sampled, no request is shown
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !irq);

    // R2: any pending trap yields a trap vector at the next update
    a_r2_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|trap_pend) |=> (irq && irq_vec < NT));

    // R6: the entry address stays inside the two tables, on entry alignment
    a_r6_addr_in_tables: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_addr >= LO && irq_addr < HI && irq_addr[0] == LO[0]));

    // R3: the vector number is always inside the map
    a_r3_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_vec < NV);

    // R7: a request is only shown if something was pending one cycle before
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((|trap_pend) || (|usr_pend)));

    // R11: with no request, the vector and address read zero
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_vec == '0 && irq_addr == '0));
endmodule

bind prio_irq_ctrl irqc_checker #(
    .N_TRAP(N_TRAP), .N_USER(N_USER), .ADDR_W(ADDR_W), .BASE(BASE), .VEC_W(VEC_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_vec(irq_vec), .irq_addr(irq_addr),
    .trap_pend(trap_pend), .usr_pend(usr_pend)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    localparam int NT = 8;
    localparam int NU = 118;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NT-1:0] trap_req;
    logic [NU-1:0] usr_req;
    logic          cfg_we;
    logic [6:0]    cfg_sel;
    logic          cfg_en;
    logic [2:0]    cfg_prio;
    logic          alt_tbl;
    logic [2:0]    cpu_prio;
    logic          ack;
    logic [6:0]    ack_vec;
    logic          irq;
    logic [6:0]    irq_vec;
    logic [23:0]   irq_addr;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .usr_req(usr_req),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
        .alt_tbl(alt_tbl), .cpu_prio(cpu_prio), .ack(ack), .ack_vec(ack_vec),
        .irq(irq), .irq_vec(irq_vec), .irq_addr(irq_addr)
    );

    typedef struct packed {
        logic [6:0] sa; logic [2:0] pa; logic ea;
        logic [6:0] sb; logic [2:0] pb;
        logic [2:0] cpu; logic alt; logic xirq; logic [6:0] xvec;
    } row_t;

    localparam row_t TBL [8] = '{
        '{7'd0,   3'd3, 1'b1, 7'd5,   3'd3, 3'd0, 1'b0, 1'b1, 7'd8},   // R5 tie
        '{7'd2,   3'd2, 1'b1, 7'd100, 3'd6, 3'd0, 1'b1, 1'b1, 7'd108}, // R5 level, R6 alt
        '{7'd10,  3'd4, 1'b1, 7'd11,  3'd4, 3'd4, 1'b0, 1'b0, 7'd0},   // R4 equal masked
        '{7'd10,  3'd5, 1'b1, 7'd11,  3'd4, 3'd4, 1'b0, 1'b1, 7'd18},  // R4 above
        '{7'd117, 3'd7, 1'b1, 7'd116, 3'd7, 3'd6, 1'b1, 1'b1, 7'd124}, // R5 tie high end
        '{7'd3,   3'd0, 1'b1, 7'd4,   3'd1, 3'd0, 1'b0, 1'b1, 7'd12},  // R4 level 0 off
        '{7'd50,  3'd7, 1'b0, 7'd60,  3'd1, 3'd0, 1'b0, 1'b1, 7'd68},  // R4 disabled
        '{7'd117, 3'd1, 1'b1, 7'd0,   3'd0, 3'd0, 1'b0, 1'b1, 7'd125}  // R3 last vector
    };

    function automatic logic [23:0] exp_addr(input int v, input bit alt);
        return 24'(4 + 2 * v + (alt ? 252 : 0));
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic check_out(input string tag, input bit xi, input int xv, input bit alt);
        check({tag, " irq"}, 32'(irq), 32'(xi));
        check({tag, " vec"}, 32'(irq_vec), xi ? 32'(xv) : 32'd0);
        check({tag, " addr"}, 32'(irq_addr), xi ? 32'(exp_addr(xv, alt)) : 32'd0);
    endtask

    task automatic cfg(input int s, input int p, input bit e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 7'(s); cfg_prio = 3'(p); cfg_en = e;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_ack(input int v);
        @(negedge clk);
        ack = 1'b1; ack_vec = 7'(v);
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_usr(input int a, input int b);
        @(negedge clk);
        usr_req[a] = 1'b1; usr_req[b] = 1'b1;
        @(negedge clk);
        usr_req = '0;
    endtask

    initial begin
        rst_n = 1'b0; trap_req = '0; usr_req = '0; cfg_we = 1'b0; cfg_sel = '0;
        cfg_en = 1'b0; cfg_prio = '0; alt_tbl = 1'b0; cpu_prio = '0;
        ack = 1'b0; ack_vec = '0;
        repeat (3) @(negedge clk);
        check_out("R1 reset", 1'b0, 0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R11 idle", 1'b0, 0, 1'b0);

        // Table walk: two sources per row
        for (int k = 0; k < 8; k++) begin
            cpu_prio = TBL[k].cpu; alt_tbl = TBL[k].alt;
            cfg(int'(TBL[k].sa), int'(TBL[k].pa), TBL[k].ea);   // R10
            cfg(int'(TBL[k].sb), int'(TBL[k].pb), 1'b1);
            pulse_usr(int'(TBL[k].sa), int'(TBL[k].sb));
            @(negedge clk);
            check_out($sformatf("R5/R4/R6 row %0d", k), TBL[k].xirq, int'(TBL[k].xvec), TBL[k].alt);
            do_ack(NT + int'(TBL[k].sa));
            do_ack(NT + int'(TBL[k].sb));
            cfg(int'(TBL[k].sa), 0, 1'b0);
            cfg(int'(TBL[k].sb), 0, 1'b0);
        end
        cpu_prio = '0; alt_tbl = 1'b0;

        // R7 latency and R2 trap precedence, R8 stickiness
        cfg(5, 7, 1'b1);
        @(negedge clk);
        trap_req[3] = 1'b1; trap_req[6] = 1'b1; usr_req[5] = 1'b1;
        @(negedge clk);
        trap_req = '0; usr_req = '0;
        check("R7 not before second edge", 32'(irq), 32'd0);
        @(negedge clk);
        check_out("R2 lowest trap", 1'b1, 3, 1'b0);
        do_ack(3);
        check_out("R8 ack clears one", 1'b1, 6, 1'b0);
        do_ack(6);
        check_out("R8 user kept pending", 1'b1, 13, 1'b0);
        do_ack(13);
        check_out("R8 all acked", 1'b0, 0, 1'b0);
        cfg(5, 0, 1'b0);

        // R2 trap ignores cpu level; R6 both tables
        cpu_prio = 3'd7; alt_tbl = 1'b1;
        @(negedge clk); trap_req[0] = 1'b1;
        @(negedge clk); trap_req = '0;
        @(negedge clk);
        check_out("R2/R6 trap0 alternate", 1'b1, 0, 1'b1);
        alt_tbl = 1'b0;
        @(negedge clk);
        check_out("R6 trap0 primary", 1'b1, 0, 1'b0);
        do_ack(0);
        cpu_prio = '0;

        // R9 capture while disabled
        cfg(20, 5, 1'b0);
        pulse_usr(20, 20);
        @(negedge clk);
        check("R9 disabled not forwarded", 32'(irq), 32'd0);
        cfg(20, 5, 1'b1);
        @(negedge clk);
        check_out("R9 forwarded after enable", 1'b1, 28, 1'b0);
        do_ack(28);
        cfg(20, 0, 1'b0);

        // R8 clear wins over a request held at the acknowledge edge
        cfg(30, 2, 1'b1);
        @(negedge clk); usr_req[30] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_out("R8 held request", 1'b1, 38, 1'b0);
        ack = 1'b1; ack_vec = 7'd38;
        @(negedge clk);
        ack = 1'b0; usr_req = '0;
        @(negedge clk);
        @(negedge clk);
        check_out("R8 clear wins", 1'b0, 0, 1'b0);
        cfg(30, 0, 1'b0);

        // R4 running-level change masks a pending source
        cfg(40, 3, 1'b1);
        pulse_usr(40, 40);
        @(negedge clk);
        check_out("R4 below level 3", 1'b1, 48, 1'b0);
        cpu_prio = 3'd3;
        @(negedge clk);
        check_out("R4 masked at equal level", 1'b0, 0, 1'b0);
        cpu_prio = 3'd2;
        @(negedge clk);
        check_out("R4 unmasked", 1'b1, 48, 1'b0);

        // R1 reset clears pending and configuration
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cpu_prio = '0;
        repeat (2) @(negedge clk);
        check_out("R1 reset clears", 1'b0, 0, 1'b0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule